// File: doc/BRIEF.md
# Write-only two-wire configuration receiver

This block is a slave receiver on a two-wire serial bus. It loads an eight-byte bank of configuration registers that the rest of the chip reads directly. An internal system clock oversamples both bus lines. Bits are taken on rising SCL edges, most significant bit first. START and STOP are recognised from SDA edges that occur while SCL is high. The only thing the block ever drives onto the bus is an acknowledge, on an open-drain pull-down output.

Every transaction has the same shape: eleven bytes. The first byte is the device address, with the write bit included. The next two bytes are clocked in and then discarded. The last eight are payload. The payload is held in a shadow buffer and copied into the live bank in a single clock only once the final byte has arrived. A frame that is aborted, or that carries the wrong address, leaves the live bank untouched. Reset puts default contents in the bank, so the chip runs correctly even if nothing is ever written.

Top module: `cfg_wire_rx`

## Requirements
- R1: After reset, cfg_o equals the DEFAULT_CFG parameter with the reserved bit cleared, and commit_o is 0.
- R2: A frame of exactly eleven bytes that starts with address 8'hD2 places payload byte k (the (k+4)th byte on the wire, bits sent MSB first) into cfg_o[8k+7:8k], and commit_o is high for exactly one clock.
- R3: The values of the second and third bytes have no effect on cfg_o.
- R4: When the first byte differs from 8'hD2, cfg_o and commit_o do not change and sda_pull_o stays low until the next START.
- R5: In a frame with a matching address, sda_pull_o is high during the ninth SCL high phase of each of the eleven bytes, and it changes only after an SCL falling edge, a START or a STOP.
- R6: A STOP that arrives before the eleventh byte completes leaves cfg_o unchanged, with no commit_o pulse.
- R7: A START in the middle of a frame discards the partial frame. A complete frame that follows it commits only its own payload.
- R8: Bit 63 (bit 7 of the last payload byte) is reserved. It always reads 0, whatever value is written to it.
- R9: cfg_o changes only in a cycle in which commit_o is high.
- R10: Bytes sent after the eleventh byte of a frame get no acknowledge and do not change cfg_o before the next START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | High to pull SDA low for an acknowledge |
| cfg_o | output | 64 | Live configuration bank, payload byte k at bits 8k+7:8k |
| commit_o | output | 1 | One-clock pulse when a frame is loaded into the bank |

## Verification
If the bit or byte counter slips, the next visible symptom is a missing or misplaced acknowledge within one byte time. Any frame that finishes afterwards then carries bytes in shifted positions on cfg_o. A sequencer that leaves its ignore state too early shows up as an acknowledge during a foreign-address frame, or during bytes past the eleventh. Stale shadow contents or a wrong abort path show up only at a commit, as a cfg_o value that does not match the last complete frame. For that reason the bench compares the whole bank, and counts commit pulses, after every frame.

// File: rtl/cfg_wire_pkg.sv
package cfg_wire_pkg;

  localparam int HDR_BYTES = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_ACK_WAIT,
    ST_ACK_HOLD,
    ST_IGNORE
  } rx_state_e;

  function automatic logic addr_hit(input logic [7:0] got, input logic [7:0] want);
    return got == want;
  endfunction

  function automatic int slot_of(input int idx);
    return idx - HDR_BYTES;
  endfunction

  function automatic logic [63:0] clear_bit(input logic [63:0] v, input int pos);
    logic [63:0] r;
    r = v;
    r[pos] = 1'b0;
    return r;
  endfunction

endpackage

// File: rtl/cfg_wire_sync.sv
module cfg_wire_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s_o,
  output logic sda_s_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);

  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s_o    = scl_ff[STAGES-1];
  assign sda_s_o    = sda_ff[STAGES-1];
  assign scl_rise_o = scl_s_o & ~scl_q;
  assign scl_fall_o = ~scl_s_o & scl_q;
  assign start_o    = scl_s_o & scl_q & sda_q & ~sda_s_o;
  assign stop_o     = scl_s_o & scl_q & ~sda_q & sda_s_o;

endmodule

// File: rtl/cfg_wire_frame.sv
module cfg_wire_frame
  import cfg_wire_pkg::*;
#(
  parameter int          NUM_DATA = 8,
  parameter logic [7:0]  DEV_ADDR = 8'hD2,
  parameter int          IDX_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_s_i,
  input  logic             scl_rise_i,
  input  logic             scl_fall_i,
  input  logic             start_i,
  input  logic             stop_i,
  output logic             byte_done_o,
  output logic             frame_done_o,
  output logic [7:0]       byte_val_o,
  output logic [IDX_W-1:0] byte_idx_o,
  output logic             ack_o
);

  localparam int TOTAL = HDR_BYTES + NUM_DATA;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL - 1);

  rx_state_e        state_q;
  logic [2:0]       bit_cnt_q;
  logic [6:0]       shreg_q;
  logic [IDX_W-1:0] idx_q;
  logic             ack_q;
  logic             addr_ok;

  assign byte_val_o   = {shreg_q, sda_s_i};
  assign byte_done_o  = (state_q == ST_SHIFT) && scl_rise_i && (bit_cnt_q == 3'd7)
                        && !start_i && !stop_i;
  assign frame_done_o = byte_done_o && (idx_q == LAST_IDX);
  assign byte_idx_o   = idx_q;
  assign ack_o        = ack_q;
  assign addr_ok      = (idx_q != '0) || addr_hit(byte_val_o, DEV_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      idx_q     <= '0;
      ack_q     <= 1'b0;
    end else if (start_i) begin
      state_q   <= ST_SHIFT;
      bit_cnt_q <= '0;
      idx_q     <= '0;
      ack_q     <= 1'b0;
    end else if (stop_i) begin
      state_q <= ST_IDLE;
      ack_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_SHIFT: begin
          if (scl_rise_i) begin
            shreg_q   <= byte_val_o[6:0];
            bit_cnt_q <= bit_cnt_q + 3'd1;
            if (bit_cnt_q == 3'd7)
              state_q <= addr_ok ? ST_ACK_WAIT : ST_IGNORE;
          end
        end
        ST_ACK_WAIT: begin
          if (scl_fall_i) begin
            ack_q   <= 1'b1;
            state_q <= ST_ACK_HOLD;
          end
        end
        ST_ACK_HOLD: begin
          if (scl_fall_i) begin
            ack_q <= 1'b0;
            if (idx_q == LAST_IDX) begin
              state_q <= ST_IGNORE;
            end else begin
              state_q <= ST_SHIFT;
              idx_q   <= idx_q + 1'b1;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // R5
  ack_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ack_q) |-> $past(scl_fall_i || start_i || stop_i));

  // R4
  ignore_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IGNORE) |-> !ack_q);

  // R10
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_q <= LAST_IDX);

endmodule

// File: rtl/cfg_wire_bank.sv
module cfg_wire_bank
  import cfg_wire_pkg::*;
#(
  parameter int                  NUM_DATA    = 8,
  parameter int                  IDX_W       = 4,
  parameter int                  RSVD_BIT    = 63,
  parameter logic [8*NUM_DATA-1:0] DEFAULT_CFG = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  byte_done_i,
  input  logic                  frame_done_i,
  input  logic [7:0]            byte_val_i,
  input  logic [IDX_W-1:0]      byte_idx_i,
  output logic [8*NUM_DATA-1:0] cfg_o,
  output logic                  commit_o
);

  localparam int CW = 8 * NUM_DATA;

  logic [NUM_DATA-1:0][7:0] shadow_q;
  logic [CW-1:0]            next_cfg;
  logic [CW-1:0]            live_q;
  logic                     commit_q;

  function automatic logic [CW-1:0] drop_rsvd(input logic [CW-1:0] v);
    logic [63:0] wide;
    wide = 64'(v);
    wide = clear_bit(wide, RSVD_BIT);
    return wide[CW-1:0];
  endfunction

  for (genvar k = 0; k < NUM_DATA - 1; k++) begin : g_shadow
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        shadow_q[k] <= '0;
      else if (byte_done_i && (slot_of(int'(byte_idx_i)) == k))
        shadow_q[k] <= byte_val_i;
    end
  end
  assign shadow_q[NUM_DATA-1] = byte_val_i;

  always_comb begin
    for (int k = 0; k < NUM_DATA; k++)
      next_cfg[8*k +: 8] = shadow_q[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q   <= drop_rsvd(DEFAULT_CFG);
      commit_q <= 1'b0;
    end else begin
      commit_q <= frame_done_i;
      if (frame_done_i)
        live_q <= drop_rsvd(next_cfg);
    end
  end

  assign cfg_o    = live_q;
  assign commit_o = commit_q;

  // R9
  live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_q |-> $stable(live_q));

  // R2
  commit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_q |=> !commit_q);

  // R8
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_q[RSVD_BIT] == 1'b0);

endmodule

// File: rtl/cfg_wire_rx.sv
module cfg_wire_rx
  import cfg_wire_pkg::*;
#(
  parameter int                    NUM_DATA    = 8,
  parameter logic [7:0]            DEV_ADDR    = 8'hD2,
  parameter int                    SYNC_STAGES = 2,
  parameter int                    RSVD_BIT    = 63,
  parameter logic [8*NUM_DATA-1:0] DEFAULT_CFG = 64'h0F1E_2D3C_4B5A_6978
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_pull_o,
  output logic [8*NUM_DATA-1:0] cfg_o,
  output logic                  commit_o
);

  localparam int IDX_W = $clog2(HDR_BYTES + NUM_DATA);

  logic             sda_s, scl_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic             byte_done, frame_done;
  logic [7:0]       byte_val;
  logic [IDX_W-1:0] byte_idx;

  cfg_wire_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_s_o    (scl_s),
    .sda_s_o    (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_ev),
    .stop_o     (stop_ev)
  );

  cfg_wire_frame #(.NUM_DATA(NUM_DATA), .DEV_ADDR(DEV_ADDR), .IDX_W(IDX_W)) u_frame (
    .clk          (clk),
    .rst_n        (rst_n),
    .sda_s_i      (sda_s),
    .scl_rise_i   (scl_rise),
    .scl_fall_i   (scl_fall),
    .start_i      (start_ev),
    .stop_i       (stop_ev),
    .byte_done_o  (byte_done),
    .frame_done_o (frame_done),
    .byte_val_o   (byte_val),
    .byte_idx_o   (byte_idx),
    .ack_o        (sda_pull_o)
  );

  cfg_wire_bank #(.NUM_DATA(NUM_DATA), .IDX_W(IDX_W), .RSVD_BIT(RSVD_BIT),
                  .DEFAULT_CFG(DEFAULT_CFG)) u_bank (
    .clk          (clk),
    .rst_n        (rst_n),
    .byte_done_i  (byte_done),
    .frame_done_i (frame_done),
    .byte_val_i   (byte_val),
    .byte_idx_i   (byte_idx),
    .cfg_o        (cfg_o),
    .commit_o     (commit_o)
  );

  // R2
  commit_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> $past(frame_done));

  // R5
  ack_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !scl_s);

endmodule

// File: tb/sim_cfg_wire_rx.sv
module sim_cfg_wire_rx;

  localparam logic [63:0] DEF = 64'h0F1E_2D3C_4B5A_6978;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull, commit;
  logic [63:0] cfg;
  wire  sda_line = sda_m & ~sda_pull;

  int checks = 0;
  int fails = 0;
  int commits = 0;
  logic [63:0] exp_cfg;

  always #5 clk = ~clk;

  cfg_wire_rx u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .cfg_o(cfg), .commit_o(commit)
  );

  always @(posedge clk) if (commit) commits <= commits + 1;

  // addr, cmd, cnt, payload, bytes sent, commit expected
  localparam int VN = 7;
  localparam logic [92:0] VEC [VN] = '{
    {8'hD2, 8'h00, 8'h00, 64'h0123_4567_89AB_CDEF, 4'd11, 1'b1},
    {8'hD2, 8'hA5, 8'h3C, 64'h7654_3210_FEDC_BA98, 4'd11, 1'b1},
    {8'hD3, 8'h00, 8'h00, 64'h1111_2222_3333_4444, 4'd11, 1'b0},
    {8'h52, 8'h00, 8'h00, 64'h5555_6666_7777_0000, 4'd11, 1'b0},
    {8'hD2, 8'h00, 8'h00, 64'h0A0B_0C0D_0E0F_1011, 4'd6,  1'b0},
    {8'hD2, 8'h77, 8'h88, 64'hFFFF_FFFF_FFFF_FFFF, 4'd11, 1'b1},
    {8'hD2, 8'h00, 8'h00, 64'h2222_3333_4444_5555, 4'd10, 1'b0}
  };

  task automatic wq(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b1; wq(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(Q); scl = 1'b1; wq(2*Q); scl = 1'b0; wq(Q);
    end
    sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q);
    acked = sda_pull;
    wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic send_frame(input logic [7:0] a, input logic [7:0] c, input logic [7:0] n8,
                            input logic [63:0] d, input int n, output logic [15:0] acks);
    logic [7:0] b;
    logic ak;
    acks = '0;
    bus_start();
    for (int i = 0; i < n; i++) begin
      if (i == 0) b = a;
      else if (i == 1) b = c;
      else if (i == 2) b = n8;
      else if (i < 11) b = d[8*(i-3) +: 8];
      else b = 8'hA5;
      send_byte(b, ak);
      acks[i] = ak;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] acks, exp_acks;
    int c0;
    wq(4);
    rst_n = 1'b1;
    wq(4);
    // R1 reset state
    exp_cfg = DEF & ~(64'd1 << 63);
    chk("R1", cfg, exp_cfg);
    chk("R1", {63'd0, commit}, 64'd0);

    for (int v = 0; v < VN; v++) begin
      logic [92:0] e;
      e = VEC[v];
      c0 = commits;
      send_frame(e[92:85], e[84:77], e[76:69], e[68:5], int'(e[4:1]), acks);
      bus_stop();
      wq(Q);
      if (e[0]) exp_cfg = e[68:5] & ~(64'd1 << 63);
      exp_acks = (e[92:85] == 8'hD2) ? ((16'd1 << e[4:1]) - 16'd1) : 16'd0;
      // R2 R3 R4 R6 R8 payload and commit count
      chk(e[0] ? "R2" : (e[92:85] != 8'hD2 ? "R4" : "R6"), cfg, exp_cfg);
      chk("R9", 64'(commits - c0), {63'd0, e[0]});
      chk(e[92:85] == 8'hD2 ? "R5" : "R4", {48'd0, acks}, {48'd0, exp_acks});
    end
    // R8 reserved bit after all-ones payload already covered by vector 5
    chk("R8", {63'd0, cfg[63]}, 64'd0);

    // R7 restart mid-frame then full frame
    c0 = commits;
    send_frame(8'hD2, 8'h00, 8'h00, 64'h1357_9BDF_0246_8ACE, 6, acks);
    send_frame(8'hD2, 8'h01, 8'h02, 64'h0246_8ACE_1357_9BDF, 11, acks);
    bus_stop();
    wq(Q);
    exp_cfg = 64'h0246_8ACE_1357_9BDF;
    chk("R7", cfg, exp_cfg);
    chk("R7", 64'(commits - c0), 64'd1);

    // R10 overlong frame
    c0 = commits;
    send_frame(8'hD2, 8'h00, 8'h00, 64'h1020_3040_5060_7080, 13, acks);
    bus_stop();
    wq(Q);
    exp_cfg = 64'h1020_3040_5060_7080;
    chk("R10", cfg, exp_cfg);
    chk("R10", {48'd0, acks}, 64'h07FF);
    chk("R10", 64'(commits - c0), 64'd1);

    // R1 reset restores defaults
    rst_n = 1'b0; wq(2); rst_n = 1'b1; wq(2);
    chk("R1", cfg, DEF & ~(64'd1 << 63));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule